// File: doc/BRIEF.md
# Accumulator CPU with Eight Opcodes

This block is a small multi-cycle processor. Its only data register is a 12-bit accumulator. Each instruction combines the accumulator with one word of a word-addressed memory, or works on the accumulator alone. The processor fetches an instruction, decodes it, and reads an operand when the instruction needs one. It uses one synchronous single-port memory. Read data comes back one clock after the address is presented, and a write completes at the clock edge where the write enable is high.

The instruction set has eight operations:
- bitwise AND with memory;
- two's-complement add from memory;
- increment a memory word and skip the next instruction on zero;
- store the accumulator and clear it;
- subroutine call that leaves a return link in memory;
- unconditional jump;
- a port transfer with a one-cycle strobe;
- a group of accumulator micro-operations, one encoding of which stops the processor.

Top module: `acc_cpu`

## Requirements
- R1: While reset is asserted (rst_n low) and in the first cycle after it, the program counter is 0 and the accumulator is 0. `mem_addr` shows 0, and `mem_we`, `io_strobe` and `halted` are low. `io_dout` is 0.
- R2: An instruction word holds the opcode in bits [11:9] and a direct address in bits [8:0]. The opcodes are AND=0, TAD=1, ISZ=2, DCA=3, JMS=4, JMP=5, IOT=6 and OPR=7. Every instruction spends one fetch cycle and one decode cycle. AND, TAD and ISZ add one operand cycle, so they take 3 clocks; all other instructions take 2.
- R3: AND sets the accumulator to the accumulator bitwise-ANDed with Mem[a].
- R4: TAD sets the accumulator to the accumulator plus Mem[a], modulo 4096. The carry out is dropped.
- R5: ISZ writes Mem[a]+1 (modulo 4096) back to Mem[a]. If the new value is zero, the next instruction is skipped.
- R6: DCA writes the accumulator to Mem[a] and then leaves the accumulator at 0.
- R7: JMS writes the address of the following instruction into Mem[a] and continues execution at a+1.
- R8: JMP continues execution at address a.
- R9: IOT raises `io_strobe` for exactly one cycle, in its decode cycle. When bit 1 is set, `io_dout` takes the accumulator value from before the instruction and holds it. When bit 0 is set, the accumulator is loaded from `io_din`.
- R10: OPR applies its micro-operations in a fixed order: bit 7 clears the accumulator, then bit 6 complements it, then bit 5 increments it (modulo 4096). Any combination of these bits may be set.
- R11: An OPR word whose bits [8:0] equal 1 stops the processor. `halted` goes high and stays high until reset, and no further memory write or address change occurs.
- R12: `mem_we` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 9 | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 12 | Memory write data |
| mem_rdata | input | 12 | Memory read data, one clock after the address |
| io_strobe | output | 1 | Port transfer strobe, one cycle wide |
| io_din | input | 12 | Data from the port |
| io_dout | output | 12 | Registered data to the port |
| halted | output | 1 | Processor has stopped |

## Verification
Each instruction's effect is due a fixed number of rising edges after the one that starts its fetch. Memory writes from DCA and JMS land on the second edge, and those from ISZ land on the third. Accumulator changes are seen only through a later store, and `halted` is high on the second edge of the halting word. The bench releases reset on a falling edge, counts edges, and samples every port on falling edges. A short store-then-halt program is therefore expected to finish in exactly 7 edges, and memory is compared only after `halted` is high. The strobe width and the absence of back-to-back writes are checked by a monitor that samples on every falling edge.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int unsigned OP_W = 3;

    // Bit positions inside the operand field of OPR and IOT words
    localparam int unsigned MB_CLR  = 7;
    localparam int unsigned MB_CMP  = 6;
    localparam int unsigned MB_INC  = 5;
    localparam int unsigned MB_SEND = 1;
    localparam int unsigned MB_LOAD = 0;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 3'd0,
        OP_TAD = 3'd1,
        OP_ISZ = 3'd2,
        OP_DCA = 3'd3,
        OP_JMS = 3'd4,
        OP_JMP = 3'd5,
        OP_IOT = 3'd6,
        OP_OPR = 3'd7
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_EXEC   = 2'd2,
        ST_HALT   = 2'd3
    } state_e;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_cpu_pkg::*;
#(
    parameter int unsigned WORD_W = 12,
    parameter int unsigned ADDR_W = 9
) (
    input  logic [WORD_W-1:0] word,
    output opcode_e           op,
    output logic [ADDR_W-1:0] operand,
    output logic              is_halt,
    output logic              uop_clr,
    output logic              uop_cmp,
    output logic              uop_inc,
    output logic              io_load,
    output logic              io_send
);

    localparam logic [ADDR_W-1:0] HALT_CODE = ADDR_W'(1);

    always_comb begin
        op      = opcode_e'(word[WORD_W-1 -: OP_W]);
        operand = word[ADDR_W-1:0];
        is_halt = (op == OP_OPR) && (operand == HALT_CODE);
        uop_clr = operand[MB_CLR];
        uop_cmp = operand[MB_CMP];
        uop_inc = operand[MB_INC];
        io_load = operand[MB_LOAD];
        io_send = operand[MB_SEND];
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_cpu_pkg::*;
#(
    parameter int unsigned WORD_W = 12
) (
    input  opcode_e           op,
    input  logic [WORD_W-1:0] acc,
    input  logic [WORD_W-1:0] mdata,
    input  logic              uop_clr,
    input  logic              uop_cmp,
    input  logic              uop_inc,
    output logic [WORD_W-1:0] result,
    output logic [WORD_W-1:0] mem_inc,
    output logic              mem_inc_zero
);

    logic [WORD_W-1:0] stage_clr;
    logic [WORD_W-1:0] stage_cmp;
    logic [WORD_W-1:0] stage_inc;

    always_comb begin
        // Micro-operation chain: clear, then complement, then increment
        stage_clr = uop_clr ? '0 : acc;
        stage_cmp = uop_cmp ? ~stage_clr : stage_clr;
        stage_inc = uop_inc ? stage_cmp + 1'b1 : stage_cmp;

        mem_inc      = mdata + 1'b1;
        mem_inc_zero = (mem_inc == '0);

        unique case (op)
            OP_AND:  result = acc & mdata;
            OP_TAD:  result = acc + mdata;
            OP_OPR:  result = stage_inc;
            default: result = acc;
        endcase
    end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int unsigned WORD_W = 12,
    parameter int unsigned ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              io_strobe,
    input  logic [WORD_W-1:0] io_din,
    output logic [WORD_W-1:0] io_dout,
    output logic              halted
);

    typedef struct packed {
        state_e            st;
        logic [ADDR_W-1:0] pc;
        logic [WORD_W-1:0] ac;
        logic [WORD_W-1:0] ir;
        logic [WORD_W-1:0] io_out;
    } regs_t;

    regs_t r_q, r_d;

    // Decoder: fresh read data during decode, latched word afterwards
    logic [WORD_W-1:0] dec_word;
    opcode_e           dec_op;
    logic [ADDR_W-1:0] dec_operand;
    logic              dec_halt;
    logic              dec_clr, dec_cmp, dec_inc;
    logic              dec_load, dec_send;

    assign dec_word = (r_q.st == ST_DECODE) ? mem_rdata : r_q.ir;

    acc_decode #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_decode (
        .word    (dec_word),
        .op      (dec_op),
        .operand (dec_operand),
        .is_halt (dec_halt),
        .uop_clr (dec_clr),
        .uop_cmp (dec_cmp),
        .uop_inc (dec_inc),
        .io_load (dec_load),
        .io_send (dec_send)
    );

    logic [WORD_W-1:0] alu_result;
    logic [WORD_W-1:0] alu_mem_inc;
    logic              alu_inc_zero;

    acc_alu #(.WORD_W(WORD_W)) u_alu (
        .op           (dec_op),
        .acc          (r_q.ac),
        .mdata        (mem_rdata),
        .uop_clr      (dec_clr),
        .uop_cmp      (dec_cmp),
        .uop_inc      (dec_inc),
        .result       (alu_result),
        .mem_inc      (alu_mem_inc),
        .mem_inc_zero (alu_inc_zero)
    );

    logic [ADDR_W-1:0] pc_next;
    assign pc_next = r_q.pc + 1'b1;

    always_comb begin
        r_d       = r_q;
        mem_addr  = r_q.pc;
        mem_we    = 1'b0;
        mem_wdata = '0;
        io_strobe = 1'b0;

        unique case (r_q.st)
            ST_FETCH: begin
                r_d.st = ST_DECODE;
            end

            ST_DECODE: begin
                r_d.ir = mem_rdata;
                r_d.st = ST_FETCH;
                unique case (dec_op)
                    OP_AND, OP_TAD, OP_ISZ: begin
                        mem_addr = dec_operand;
                        r_d.st   = ST_EXEC;
                    end
                    OP_DCA: begin
                        mem_addr  = dec_operand;
                        mem_we    = 1'b1;
                        mem_wdata = r_q.ac;
                        r_d.ac    = '0;
                        r_d.pc    = pc_next;
                    end
                    OP_JMS: begin
                        mem_addr  = dec_operand;
                        mem_we    = 1'b1;
                        mem_wdata = WORD_W'(pc_next);
                        r_d.pc    = dec_operand + 1'b1;
                    end
                    OP_JMP: begin
                        r_d.pc = dec_operand;
                    end
                    OP_IOT: begin
                        io_strobe = 1'b1;
                        if (dec_send) r_d.io_out = r_q.ac;
                        if (dec_load) r_d.ac = io_din;
                        r_d.pc = pc_next;
                    end
                    default: begin
                        if (dec_halt) begin
                            r_d.st = ST_HALT;
                        end else begin
                            r_d.ac = alu_result;
                            r_d.pc = pc_next;
                        end
                    end
                endcase
            end

            ST_EXEC: begin
                r_d.st = ST_FETCH;
                r_d.pc = pc_next;
                if (dec_op == OP_ISZ) begin
                    mem_addr  = dec_operand;
                    mem_we    = 1'b1;
                    mem_wdata = alu_mem_inc;
                    if (alu_inc_zero) r_d.pc = r_q.pc + ADDR_W'(2);
                end else begin
                    r_d.ac = alu_result;
                end
            end

            default: begin
                r_d.st = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_FETCH, pc: '0, ac: '0, ir: '0, io_out: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign io_dout = r_q.io_out;
    assign halted  = (r_q.st == ST_HALT);

    // Plain views of the state for the bound checker
    state_e            state_q;
    logic [ADDR_W-1:0] pc_q;
    logic [WORD_W-1:0] ac_q;
    assign state_q = r_q.st;
    assign pc_q    = r_q.pc;
    assign ac_q    = r_q.ac;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_cpu_pkg::*;
#(
    parameter int unsigned WORD_W = 12,
    parameter int unsigned ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_rdata,
    input logic              io_strobe,
    input logic              halted,
    input state_e            state_q,
    input logic [ADDR_W-1:0] pc_q,
    input logic [WORD_W-1:0] ac_q
);

    opcode_e rd_op;
    assign rd_op = opcode_e'(mem_rdata[WORD_W-1 -: OP_W]);

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R12

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        io_strobe |=> !io_strobe); // R9

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_we && $stable(mem_addr))); // R11

    AST_DCA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE && rd_op == OP_DCA) |=> (ac_q == '0)); // R6

    AST_JMP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE && rd_op == OP_JMP)
            |=> (pc_q == $past(mem_rdata[ADDR_W-1:0]))); // R8

    AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |-> (mem_addr == pc_q && !mem_we)); // R2

endmodule

bind acc_cpu acc_cpu_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .io_strobe (io_strobe),
    .halted    (halted),
    .state_q   (state_q),
    .pc_q      (pc_q),
    .ac_q      (ac_q)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 12;
    localparam int ADDR_W     = 9;
    localparam int MEM_DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_we;
    logic [WORD_W-1:0] mem_wdata;
    logic [WORD_W-1:0] mem_rdata;
    logic              io_strobe;
    logic [WORD_W-1:0] io_din = '0;
    logic [WORD_W-1:0] io_dout;
    logic              halted;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_cpu #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .io_strobe (io_strobe),
        .io_din    (io_din),
        .io_dout   (io_dout),
        .halted    (halted)
    );

    // Synchronous single-port memory model
    logic [WORD_W-1:0] mem [0:MEM_DEPTH-1];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    // Port monitor, sampled on falling edges
    int  strobe_cnt = 0;
    int  we_pairs   = 0;
    int  we_cnt     = 0;
    logic prev_we   = 1'b0;
    logic prev_stb  = 1'b0;
    int  stb_pairs  = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (io_strobe) strobe_cnt++;
            if (mem_we) we_cnt++;
            if (mem_we && prev_we) we_pairs++;
            if (io_strobe && prev_stb) stb_pairs++;
        end
        prev_we  = mem_we && rst_n;
        prev_stb = io_strobe && rst_n;
    end

    function automatic logic [WORD_W-1:0] enc(input int op, input int a);
        logic [2:0] o = 3'(op);
        logic [8:0] f = 9'(a);
        return {o, f};
    endfunction

    localparam logic [WORD_W-1:0] HLT = 12'hE01;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < MEM_DEPTH; i++) mem[i] = '0;
    endtask

    task automatic run(output int cyc);
        rst_n = 1'b0;
        @(negedge clk);
        strobe_cnt = 0;
        we_cnt     = 0;
        rst_n = 1'b1;
        cyc = 0;
        while (!halted && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic t_reset();
        clear_mem();
        mem[0] = HLT;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 addr in reset", int'(mem_addr), 0);
        check("R1 halted in reset", int'(halted), 0);
        check("R1 strobe/we in reset", int'({io_strobe, mem_we}), 0);
        check("R1 io_dout in reset", int'(io_dout), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 still quiet after release", int'({halted, io_strobe, mem_we}), 0);
    endtask

    task automatic t_timing();
        int cyc;
        clear_mem();
        mem[0]  = enc(1, 10);
        mem[1]  = enc(3, 11);
        mem[2]  = HLT;
        mem[10] = 12'h005;
        run(cyc);
        check("R2 cycles TAD+DCA+HLT", cyc, 7);
        check("R2 stored value", int'(mem[11]), 12'h005);
    endtask

    task automatic t_and();
        int cyc;
        clear_mem();
        mem[0] = enc(1, 20);
        mem[1] = enc(0, 21);
        mem[2] = enc(3, 22);
        mem[3] = HLT;
        mem[20] = 12'hF0F;
        mem[21] = 12'h3C3;
        run(cyc);
        check("R3 AND result", int'(mem[22]), 12'h303);
    endtask

    task automatic t_tad_dca();
        int cyc;
        clear_mem();
        mem[0] = enc(1, 20);
        mem[1] = enc(1, 21);
        mem[2] = enc(3, 22);
        mem[3] = enc(3, 23);
        mem[4] = HLT;
        mem[20] = 12'hFFF;
        mem[21] = 12'h002;
        mem[23] = 12'h777;
        run(cyc);
        check("R4 TAD wraps", int'(mem[22]), 12'h001);
        check("R6 DCA clears AC", int'(mem[23]), 0);
    endtask

    task automatic t_isz();
        int cyc;
        clear_mem();
        mem[0] = enc(2, 20);
        mem[1] = enc(2, 20);
        mem[2] = enc(1, 21);
        mem[3] = enc(3, 22);
        mem[4] = HLT;
        mem[20] = 12'hFFE;
        mem[21] = 12'h111;
        mem[22] = 12'h555;
        run(cyc);
        check("R5 ISZ wrote back wrapped", int'(mem[20]), 0);
        check("R5 ISZ skipped on zero", int'(mem[22]), 0);
        check("R2 ISZ program cycles", cyc, 3 + 3 + 2 + 2);
    endtask

    task automatic t_jms();
        int cyc;
        clear_mem();
        mem[0]  = enc(4, 30);
        mem[1]  = HLT;
        mem[31] = enc(1, 40);
        mem[32] = enc(3, 41);
        mem[33] = enc(5, 1);
        mem[40] = 12'h0AB;
        run(cyc);
        check("R7 JMS link", int'(mem[30]), 1);
        check("R7 JMS body ran", int'(mem[41]), 12'h0AB);
        check("R8 JMP back reached halt", int'(halted), 1);
    endtask

    task automatic t_jmp();
        int cyc;
        clear_mem();
        mem[0] = enc(5, 5);
        mem[1] = enc(1, 50);
        mem[2] = enc(3, 52);
        mem[3] = HLT;
        mem[5] = enc(1, 51);
        mem[6] = enc(3, 52);
        mem[7] = HLT;
        mem[50] = 12'h999;
        mem[51] = 12'h042;
        run(cyc);
        check("R8 JMP target", int'(mem[52]), 12'h042);
    endtask

    task automatic t_iot();
        int cyc;
        clear_mem();
        io_din = 12'h6A5;
        mem[0]  = enc(1, 60);
        mem[1]  = enc(6, 3);
        mem[2]  = enc(3, 61);
        mem[3]  = HLT;
        mem[60] = 12'h321;
        run(cyc);
        check("R9 io_dout old AC", int'(io_dout), 12'h321);
        check("R9 AC loaded from io_din", int'(mem[61]), 12'h6A5);
        check("R9 one strobe cycle", strobe_cnt, 1);
        check("R9 strobe never wide", stb_pairs, 0);
    endtask

    task automatic t_opr();
        int cyc;
        clear_mem();
        mem[0]  = enc(1, 70);
        mem[1]  = enc(7, 12'h0E0);
        mem[2]  = enc(3, 71);
        mem[3]  = enc(1, 70);
        mem[4]  = enc(7, 12'h040);
        mem[5]  = enc(3, 72);
        mem[6]  = enc(1, 70);
        mem[7]  = enc(7, 12'h060);
        mem[8]  = enc(3, 73);
        mem[9]  = enc(1, 70);
        mem[10] = enc(7, 12'h0A0);
        mem[11] = enc(3, 74);
        mem[12] = HLT;
        mem[70] = 12'h00F;
        mem[71] = 12'h555;
        run(cyc);
        check("R10 clr+cmp+inc", int'(mem[71]), 0);
        check("R10 cmp only", int'(mem[72]), 12'hFF0);
        check("R10 cmp then inc", int'(mem[73]), 12'hFF1);
        check("R10 clr then inc", int'(mem[74]), 12'h001);
    endtask

    task automatic t_halt();
        int cyc;
        logic [ADDR_W-1:0] a0;
        clear_mem();
        mem[0] = HLT;
        mem[1] = enc(3, 80);
        mem[80] = 12'h123;
        run(cyc);
        check("R11 halt after two cycles", cyc, 2);
        a0 = mem_addr;
        we_cnt = 0;
        repeat (20) @(negedge clk);
        check("R11 stays halted", int'(halted), 1);
        check("R11 no writes while halted", we_cnt, 0);
        check("R11 address frozen", int'(mem_addr), int'(a0));
        check("R11 later word not run", int'(mem[80]), 12'h123);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_reset();
        t_timing();
        t_and();
        t_tad_dca();
        t_isz();
        t_jms();
        t_jmp();
        t_iot();
        t_opr();
        t_halt();
        check("R12 no back-to-back writes", we_pairs, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule